// File: doc/BRIEF.md
# Byte-wide host mailbox for an internal register space

This block lets a host reach a 256-byte internal register space through two byte-wide ports instead of a direct memory map. The host writes to a control port to issue a command and to a data port to pass address and data bytes. It reads the control port to get a status byte, and reads the data port to collect results. Two flow-control flags pace the exchange:

- The input-full flag tells the host that its last byte has not been taken yet.
- The output-full flag tells the host that a result byte is waiting.

Inside, a small sequencer takes each host byte a fixed number of cycles after it arrives. It decodes the byte stream and drives a plain register bus with an address, write data, a one-cycle write strobe, a one-cycle read strobe and read data. Read data is sampled one cycle after the read strobe.

The command codes are:

| Code | Meaning |
|------|---------|
| 0x80 | Read |
| 0x81 | Write |
| 0x82 | Burst flag on |
| 0x83 | Burst flag off |
| 0x84 | Query |

A read is the read command followed by one address byte. A write is the write command followed by an address byte and then a data byte. The burst flag is only reported and changes no timing. A query answers 0x00, meaning no event is pending.

Top module: `ecmb_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00, and neither register strobe is active.
- R2: Any host write to either port sets the input-full flag (status bit 1) in the next cycle. The flag stays set for exactly CONSUME_LAT cycles and then clears. Status bit 3 reads 1 when the most recent host write went to the control port and 0 when it went to the data port.
- R3: Control byte 0x80 followed by an address byte on the data port produces one read strobe carrying that address. The register read data then appears on the data port with the output-full flag (status bit 0) set, CONSUME_LAT+1 cycles after the address byte was written.
- R4: A host read of the data port while the output-full flag is set clears the flag. A read while the flag is clear returns the same byte again and leaves the flag clear.
- R5: Control byte 0x81 followed by an address byte and a data byte produces exactly one write strobe carrying that address and data, with no read strobe.
- R6: The write strobe and the read strobe are never active in the same cycle, and each lasts a single cycle.
- R7: A recognised command byte abandons any partly received sequence, and decoding restarts from that command.
- R8: A control byte that is not one of 0x80 to 0x84 is ignored, and a sequence already in progress continues as if it had not arrived.
- R9: Command 0x82 sets status bit 4 and command 0x83 clears it. The bit changes only on those commands, and read latency is the same whether it is set or clear.
- R10: Command 0x84 places 0x00 on the data port with the output-full flag set.
- R11: A data-port byte that arrives with no command pending is discarded, with no strobe and no change to the output-full flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe, one cycle per byte |
| hst_rd | input | 1 | Host read strobe; on the data port it drains the result |
| hst_sel | input | 1 | Port select: 0 = data port, 1 = control port |
| hst_wdata | input | 8 | Byte written by the host |
| hst_rdata | output | 8 | Data port byte or status byte, chosen by hst_sel |
| reg_addr | output | 8 | Internal register address |
| reg_wdata | output | 8 | Internal register write data |
| reg_we | output | 1 | Internal write strobe |
| reg_re | output | 1 | Internal read strobe |
| reg_rdata | input | 8 | Internal register read data, sampled the cycle after reg_re |

## Verification
The bench sweeps every one of the 256 addresses, first with writes of a computed pattern and then with reads compared against that pattern. A sequencer that loses or reorders address bytes shows up there as the wrong byte.

The flow-control flags are timed cycle by cycle, and read latency is measured with the burst flag both set and clear. Wrong hold counts or a burst-dependent path therefore show as a cycle offset.

Aborted sequences, unknown commands in mid-sequence, stray data bytes and repeated data-port reads are all targeted. A design that mishandles any of them issues a stray write, drops a legitimate one, or raises the output flag spuriously.

// File: rtl/ecmb_pkg.sv
package ecmb_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_READ      = 8'h80;
    localparam byte_t OP_WRITE     = 8'h81;
    localparam byte_t OP_BURST_ON  = 8'h82;
    localparam byte_t OP_BURST_OFF = 8'h83;
    localparam byte_t OP_QUERY     = 8'h84;

    // Status byte bit positions
    localparam int SB_OBF   = 0;
    localparam int SB_IBF   = 1;
    localparam int SB_CMD   = 3;
    localparam int SB_BURST = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_WR_ADDR,
        SQ_WR_DATA,
        SQ_RD_WAIT
    } seq_e;
endpackage

// File: rtl/ecmb_inbuf.sv
module ecmb_inbuf
    import ecmb_pkg::*;
#(
    parameter int CONSUME_LAT = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_is_cmd,
    input  byte_t wr_byte,
    input  logic  take_ok,
    output logic  ibf,
    output logic  last_cmd,
    output logic  consume,
    output byte_t in_byte,
    output logic  in_is_cmd
);
    localparam int CNT_W = (CONSUME_LAT > 1) ? $clog2(CONSUME_LAT) : 1;

    typedef struct packed {
        logic             ibf;
        logic             is_cmd;
        logic             last_cmd;
        byte_t            data;
        logic [CNT_W-1:0] cnt;
    } ib_s;

    ib_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        consume = s_q.ibf && (s_q.cnt == '0) && take_ok;
        if (consume) begin
            s_d.ibf = 1'b0;
        end else if (s_q.ibf && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (wr_en) begin
            s_d.ibf      = 1'b1;
            s_d.data     = wr_byte;
            s_d.is_cmd   = wr_is_cmd;
            s_d.last_cmd = wr_is_cmd;
            s_d.cnt      = CNT_W'(CONSUME_LAT - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ibf       = s_q.ibf;
    assign last_cmd  = s_q.last_cmd;
    assign in_byte   = s_q.data;
    assign in_is_cmd = s_q.is_cmd;

    AST_IBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ibf);  // R2
    AST_IBF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && !consume) |=> ibf);  // R2
endmodule

// File: rtl/ecmb_seq.sv
module ecmb_seq
    import ecmb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  consume,
    input  byte_t in_byte,
    input  logic  in_is_cmd,
    input  logic  host_drain,
    input  byte_t reg_rdata,
    output logic  take_ok,
    output byte_t reg_addr,
    output byte_t reg_wdata,
    output logic  reg_we,
    output logic  reg_re,
    output byte_t out_byte,
    output logic  obf,
    output logic  burst
);
    typedef struct packed {
        seq_e  state;
        byte_t addr;
        byte_t wdata;
        logic  we;
        logic  re;
        byte_t out_byte;
        logic  obf;
        logic  burst;
    } sq_s;

    sq_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.we  = 1'b0;
        s_d.re  = 1'b0;
        take_ok = (s_q.state != SQ_RD_WAIT);
        if (host_drain && s_q.obf) s_d.obf = 1'b0;

        if (s_q.state == SQ_RD_WAIT) begin
            s_d.out_byte = reg_rdata;
            s_d.obf      = 1'b1;
            s_d.state    = SQ_IDLE;
        end else if (consume && in_is_cmd) begin
            case (in_byte)
                OP_READ:      s_d.state = SQ_RD_ADDR;
                OP_WRITE:     s_d.state = SQ_WR_ADDR;
                OP_BURST_ON:  begin s_d.burst = 1'b1; s_d.state = SQ_IDLE; end
                OP_BURST_OFF: begin s_d.burst = 1'b0; s_d.state = SQ_IDLE; end
                OP_QUERY: begin
                    s_d.out_byte = '0;
                    s_d.obf      = 1'b1;
                    s_d.state    = SQ_IDLE;
                end
                default: ;
            endcase
        end else if (consume) begin
            case (s_q.state)
                SQ_RD_ADDR: begin
                    s_d.addr  = in_byte;
                    s_d.re    = 1'b1;
                    s_d.state = SQ_RD_WAIT;
                end
                SQ_WR_ADDR: begin
                    s_d.addr  = in_byte;
                    s_d.state = SQ_WR_DATA;
                end
                SQ_WR_DATA: begin
                    s_d.wdata = in_byte;
                    s_d.we    = 1'b1;
                    s_d.state = SQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign reg_addr  = s_q.addr;
    assign reg_wdata = s_q.wdata;
    assign reg_we    = s_q.we;
    assign reg_re    = s_q.re;
    assign out_byte  = s_q.out_byte;
    assign obf       = s_q.obf;
    assign burst     = s_q.burst;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));  // R6
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);  // R6
    AST_RE_THEN_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> obf);  // R3
    AST_OBF_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (host_drain && obf && !reg_re && !consume) |=> !obf);  // R4
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !consume |=> $stable(burst));  // R9
endmodule

// File: rtl/ecmb_port.sv
module ecmb_port
    import ecmb_pkg::*;
#(
    parameter int CONSUME_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hst_wr,
    input  logic       hst_rd,
    input  logic       hst_sel,
    input  logic [7:0] hst_wdata,
    output logic [7:0] hst_rdata,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    input  logic [7:0] reg_rdata
);
    logic  ibf, last_cmd, consume, in_is_cmd, take_ok, obf, burst;
    byte_t in_byte, out_byte, status;

    ecmb_inbuf #(.CONSUME_LAT(CONSUME_LAT)) u_inbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hst_wr),
        .wr_is_cmd(hst_sel),
        .wr_byte  (hst_wdata),
        .take_ok  (take_ok),
        .ibf      (ibf),
        .last_cmd (last_cmd),
        .consume  (consume),
        .in_byte  (in_byte),
        .in_is_cmd(in_is_cmd)
    );

    ecmb_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .consume   (consume),
        .in_byte   (in_byte),
        .in_is_cmd (in_is_cmd),
        .host_drain(hst_rd && !hst_sel),
        .reg_rdata (reg_rdata),
        .take_ok   (take_ok),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .out_byte  (out_byte),
        .obf       (obf),
        .burst     (burst)
    );

    always_comb begin
        status           = '0;
        status[SB_OBF]   = obf;
        status[SB_IBF]   = ibf;
        status[SB_CMD]   = last_cmd;
        status[SB_BURST] = burst;
    end

    assign hst_rdata = hst_sel ? status : out_byte;

    AST_WRITE_RAISES_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        hst_wr |=> hst_rdata[SB_IBF] || !hst_sel || ibf);  // R2
endmodule

// File: tb/ecmb_port_bench.sv
module ecmb_port_bench;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_wr = 1'b0, hst_rd = 1'b0, hst_sel = 1'b1;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata, reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;

    always #2 clk = ~clk;

    ecmb_port #(.CONSUME_LAT(LAT)) u_ecmb_port (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    logic [7:0] mem [256];
    int we_cnt = 0, re_cnt = 0, strobe_viol = 0;
    logic prev_we = 1'b0, prev_re = 1'b0;
    logic [7:0] last_wa, last_wd, last_ra;
    int n_chk = 0, n_bad = 0;

    assign reg_rdata = mem[reg_addr];

    initial for (int i = 0; i < 256; i++) mem[i] = 8'hEE;

    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                mem[reg_addr] = reg_wdata;
                we_cnt++; last_wa = reg_addr; last_wd = reg_wdata;
            end
            if (reg_re) begin re_cnt++; last_ra = reg_addr; end
            if ((reg_we && reg_re) || (reg_we && prev_we) || (reg_re && prev_re))
                strobe_viol++;
            prev_we = reg_we; prev_re = reg_re;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(((a * 29 + 7) & 255) ^ 8'h5A);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic get_status(output logic [7:0] s);
        hst_sel = 1'b1; #1; s = hst_rdata;
    endtask

    task automatic hwrite(input logic sel, input logic [7:0] b);
        logic [7:0] s;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); get_status(s);
            if (!s[1]) break;
        end
        hst_sel = sel; hst_wdata = b; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0; hst_sel = 1'b1;
    endtask

    task automatic hread_raw(output logic [7:0] b);
        hst_sel = 1'b0; #1; b = hst_rdata; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0; hst_sel = 1'b1;
    endtask

    task automatic hread(output logic [7:0] b);
        logic [7:0] s;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); get_status(s);
            if (s[0]) break;
        end
        hread_raw(b);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        hwrite(1'b1, 8'h81); hwrite(1'b0, a); hwrite(1'b0, d);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        hwrite(1'b1, 8'h80); hwrite(1'b0, a); hread(d);
    endtask

    task automatic settle();
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic timed_read(input logic [7:0] a, output int n);
        logic [7:0] s, d;
        hwrite(1'b1, 8'h80); hwrite(1'b0, a);
        n = 1; get_status(s);
        while (!s[0] && n < 50) begin @(negedge clk); n++; get_status(s); end
        hread_raw(d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] s, d, d2;
        int w0, r0, n1, n2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        get_status(s); check(s == 8'h00, "R1 status", s, 0);
        hst_sel = 1'b0; #1; check(hst_rdata == 8'h00, "R1 data", hst_rdata, 0); hst_sel = 1'b1;
        check(!reg_we && !reg_re, "R1 strobes", {reg_we, reg_re}, 0);

        // R2 IBF timing on a data byte, which also exercises R11
        w0 = we_cnt; r0 = re_cnt;
        hwrite(1'b0, 8'h11);
        for (int k = 1; k <= LAT; k++) begin
            get_status(s);
            check(s[1] == 1'b1, "R2 ibf held", s, 8'h02);
            check(s[3] == 1'b0, "R2 cmd flag clear", s[3], 0);
            @(negedge clk);
        end
        get_status(s); check(s[1] == 1'b0, "R2 ibf cleared", s[1], 0);
        settle();
        get_status(s); check(s[0] == 1'b0, "R11 no obf", s[0], 0);
        check(we_cnt == w0 && re_cnt == r0, "R11 no strobe", we_cnt + re_cnt, w0 + r0);
        hwrite(1'b1, 8'h83);
        get_status(s); check(s[3] == 1'b1 && s[1] == 1'b1, "R2 cmd flag set", s, 8'h0A);

        // R5 write sweep over all addresses
        for (int a = 0; a < 256; a++) begin
            w0 = we_cnt; r0 = re_cnt;
            do_write(8'(a), pat(a));
            settle();
            check(we_cnt == w0 + 1, "R5 one write", we_cnt - w0, 1);
            check(re_cnt == r0, "R5 no read", re_cnt - r0, 0);
            check(last_wa == 8'(a) && last_wd == pat(a), "R5 addr/data",
                  {last_wa, last_wd}, {8'(a), pat(a)});
        end

        // R3 read sweep over all addresses
        for (int a = 0; a < 256; a++) begin
            r0 = re_cnt;
            do_read(8'(a), d);
            check(d == pat(a), "R3 read data", d, pat(a));
            check(re_cnt == r0 + 1 && last_ra == 8'(a), "R3 one read", last_ra, a);
        end

        // R4 drain then repeat read
        do_read(8'h07, d);
        get_status(s); check(s[0] == 1'b0, "R4 obf cleared", s[0], 0);
        hread_raw(d2); check(d2 == d, "R4 repeat value", d2, d);
        get_status(s); check(s[0] == 1'b0, "R4 obf stays clear", s[0], 0);

        // R10 query
        do_read(8'h05, d);
        hwrite(1'b1, 8'h84); hread(d);
        check(d == 8'h00, "R10 query byte", d, 0);

        // R9 burst flag and latency
        timed_read(8'h10, n1);
        check(n1 == LAT + 2, "R9 latency burst off", n1, LAT + 2);
        hwrite(1'b1, 8'h82); settle();
        get_status(s); check(s[4] == 1'b1, "R9 burst set", s[4], 1);
        timed_read(8'h11, n2);
        check(n2 == n1, "R9 latency burst on", n2, n1);
        get_status(s); check(s[4] == 1'b1, "R9 burst kept", s[4], 1);
        hwrite(1'b1, 8'h83); settle();
        get_status(s); check(s[4] == 1'b0, "R9 burst cleared", s[4], 0);

        // R7 abort a write by a read
        w0 = we_cnt;
        hwrite(1'b1, 8'h81); hwrite(1'b0, 8'h20);
        do_read(8'h21, d);
        check(d == pat(8'h21), "R7 read after abort", d, pat(8'h21));
        check(we_cnt == w0, "R7 no write", we_cnt - w0, 0);
        hwrite(1'b1, 8'h81); hwrite(1'b0, 8'h30);
        do_write(8'h31, 8'h99); settle();
        do_read(8'h30, d); check(d == pat(8'h30), "R7 first addr untouched", d, pat(8'h30));
        do_read(8'h31, d); check(d == 8'h99, "R7 restarted write", d, 8'h99);

        // R8 unknown command mid-sequence
        w0 = we_cnt;
        hwrite(1'b1, 8'h81); hwrite(1'b0, 8'h40);
        hwrite(1'b1, 8'h55); hwrite(1'b0, 8'hC3); settle();
        check(we_cnt == w0 + 1, "R8 write continues", we_cnt - w0, 1);
        do_read(8'h40, d); check(d == 8'hC3, "R8 data", d, 8'hC3);
        get_status(s); check(s[4] == 1'b0 && s[0] == 1'b0, "R8 flags unchanged", s, 0);

        // R6 strobe shape across the whole run
        check(strobe_viol == 0, "R6 strobe shape", strobe_viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule